// File: doc/BRIEF.md
# Deductive Fault-List Sweep Engine

The engine takes one three-bit input pattern and works out, for every wire of a small fixed combinational netlist, which single stuck-at faults would make that wire differ from its fault-free value. Each fault set is a bit vector with one bit per fault. Fault `2*w + s` is wire `w` stuck at value `s`. The netlist has eleven wires, so there are 22 faults. A caller-supplied universe mask picks which of these faults are modeled.

After a start pulse the engine captures the pattern and the universe. It loads the lists of the primary inputs, then evaluates one gate per clock in topological order. For each gate it computes the good value and the output fault list together, from the lists and good values of the gate's inputs. When the last gate is done it raises `done`. `detected` then holds the union of the fault lists of the two primary outputs. Every per-wire list and good value is also visible on the ports.

Wire indices are A=0, B=1, F=2, C=3, D=4, E=5, G=6, H=7, J=8, K=9, M=10. `pattern[0]` drives A, `pattern[1]` drives B and `pattern[2]` drives F. The gates, in sweep order, are:

1. C = buffer branch of B
2. D = buffer branch of B
3. E = NOT D
4. G = AND(A,C)
5. H = AND(E,F)
6. J = OR(H,G)
7. K = NAND(A,E)
8. M = NOR(K,F)

J and M are the primary outputs.

Top module: `dfsim_sweep`

## Requirements
- R1: While reset is low and after its release, `busy`, `done`, `detected`, `wire_lists` and `wire_vals` are all zero.
- R2: A start pulse seen while idle captures the pattern and the universe. Each primary input's list then holds only bit `2*w + (1 - value)`, masked by the universe. The branches C and D carry B's list plus their own opposite-polarity fault.
- R3: `busy` is high on the cycle after the start edge. One gate is evaluated per clock, and `done` rises exactly 8 clock edges after the start edge, with `busy` falling in the same cycle.
- R4: When no input of a gate is at the controlling value, the gate's list is the union of its input lists plus the output's own fault.
- R5: When some input is at the controlling value, the list is the intersection of the controlling inputs' lists, minus the union of the non-controlling inputs' lists, plus the output's own fault.
- R6: AND and NAND have controlling value 0; OR and NOR have controlling value 1. Inversion changes only the good value, and so which own-fault bit (`2*w + (1 - good value)`) is added. `wire_vals` carries the fault-free value of every wire.
- R7: Once `done` is high, `detected` equals the union of the lists of J (wire 8) and M (wire 10).
- R8: No list and no `detected` bit is ever set for a fault that is outside the captured universe.
- R9: A start pulse that arrives while `busy` is high is ignored. It changes neither the timing nor any result.
- R10: For pattern A=1, B=0, F=1 with every fault modeled, J's list is exactly {D/1, E/0, F/0, H/0, J/0}, which is bits 9, 10, 4, 14 and 16.
- R11: Results hold while `done` is high and no start arrives. The next accepted start clears `done` on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sweep with the current pattern and universe (ignored while busy) |
| pattern | input | 3 | Primary input values: bit 0 = A, bit 1 = B, bit 2 = F |
| universe | input | 22 | Mask of modeled faults; bit `2*w+s` = wire w stuck at s |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Sweep finished; results valid until the next accepted start |
| detected | output | 22 | Union of the primary-output fault lists |
| wire_vals | output | 11 | Fault-free value of every wire |
| wire_lists | output | 242 | Fault list of wire w at bits `[w*22 +: 22]` |

## Verification
Capturing the start takes one edge, so `busy` is sampled on the falling edge just after it. `done` is due after eight more rising edges, one per gate. The bench therefore checks that `done` is still low on the falling edge after the seventh gate edge and high after the eighth. Lists, values and `detected` are compared only after that point, against a reference that simulates each single fault explicitly. A start injected in the middle of a sweep, and the hold cycles after `done`, are checked on the same falling-edge grid.

// File: rtl/dfsim_pkg.sv
package dfsim_pkg;
  localparam int NUM_PI     = 3;
  localparam int NUM_WIRES  = 11;
  localparam int NUM_GATES  = 8;
  localparam int NUM_FAULTS = 2 * NUM_WIRES;
  localparam int WIRE_W     = $clog2(NUM_WIRES);
  localparam int STEP_W     = $clog2(NUM_GATES);

  // primary outputs: J (8) and M (10)
  localparam logic [NUM_WIRES-1:0] PO_MASK = 11'b101_0000_0000;

  typedef enum logic [1:0] {GK_AND, GK_OR, GK_NAND, GK_NOR} gate_kind_e;

  typedef struct packed {
    gate_kind_e         kind;
    logic [WIRE_W-1:0]  in0;
    logic [WIRE_W-1:0]  in1;
    logic [WIRE_W-1:0]  out;
  } gate_t;

  // topological gate order; single-input gates repeat their input
  function automatic gate_t gate_at(input logic [STEP_W-1:0] s);
    gate_t g;
    case (s)
      3'd0:    g = '{GK_AND,  4'd1, 4'd1, 4'd3};   // C branch of B
      3'd1:    g = '{GK_AND,  4'd1, 4'd1, 4'd4};   // D branch of B
      3'd2:    g = '{GK_NAND, 4'd4, 4'd4, 4'd5};   // E = ~D
      3'd3:    g = '{GK_AND,  4'd0, 4'd3, 4'd6};   // G
      3'd4:    g = '{GK_AND,  4'd5, 4'd2, 4'd7};   // H
      3'd5:    g = '{GK_OR,   4'd7, 4'd6, 4'd8};   // J
      3'd6:    g = '{GK_NAND, 4'd0, 4'd5, 4'd9};   // K
      default: g = '{GK_NOR,  4'd9, 4'd2, 4'd10};  // M
    endcase
    return g;
  endfunction
endpackage

// File: rtl/dfsim_step_ctrl.sv
module dfsim_step_ctrl #(
  parameter int NUM_GATES = 8,
  parameter int STEP_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic [STEP_W-1:0] step,
  output logic              load,
  output logic              adv
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(NUM_GATES - 1);

  logic              busy_d, done_d;
  logic [STEP_W-1:0] step_d;

  assign load = start && !busy;
  assign adv  = busy;

  always_comb begin
    busy_d = busy;
    done_d = done;
    step_d = step;
    if (load) begin
      busy_d = 1'b1;
      done_d = 1'b0;
      step_d = '0;
    end else if (busy) begin
      if (step == LAST) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        step_d = step + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      step <= '0;
    end else begin
      busy <= busy_d;
      done <= done_d;
      step <= step_d;
    end
  end
endmodule

// File: rtl/dfsim_gate_eval.sv
module dfsim_gate_eval
  import dfsim_pkg::*;
#(
  parameter int NF = 22,
  parameter int WW = 4
) (
  input  gate_kind_e       kind,
  input  logic [NF-1:0]    la,
  input  logic [NF-1:0]    lb,
  input  logic             va,
  input  logic             vb,
  input  logic [WW-1:0]    out_idx,
  input  logic [NF-1:0]    univ,
  output logic             y,
  output logic [NF-1:0]    lst
);
  logic          ctl, inv, ca, cb;
  logic [NF-1:0] comb_l, own;

  always_comb begin
    ctl = (kind == GK_OR)   || (kind == GK_NOR);
    inv = (kind == GK_NAND) || (kind == GK_NOR);
    ca  = (va == ctl);
    cb  = (vb == ctl);
    case ({ca, cb})
      2'b00:   comb_l = la | lb;
      2'b11:   comb_l = la & lb;
      2'b10:   comb_l = la & ~lb;
      default: comb_l = lb & ~la;
    endcase
    y   = ((ca || cb) ? ctl : ~ctl) ^ inv;
    own = {{(NF-1){1'b0}}, 1'b1} << {out_idx, ~y};
    lst = (comb_l | own) & univ;
  end
endmodule

// File: rtl/dfsim_po_union.sv
module dfsim_po_union #(
  parameter int                NW      = 11,
  parameter int                NF      = 22,
  parameter logic [NW-1:0]     PO_SEL  = '1
) (
  input  logic [NW*NF-1:0] lists,
  output logic [NF-1:0]    detected
);
  always_comb begin
    detected = '0;
    for (int w = 0; w < NW; w++) begin
      if (PO_SEL[w]) detected = detected | lists[w*NF +: NF];
    end
  end
endmodule

// File: rtl/dfsim_sweep.sv
module dfsim_sweep
  import dfsim_pkg::*;
#(
  parameter int NPI = NUM_PI,
  parameter int NW  = NUM_WIRES,
  parameter int NF  = NUM_FAULTS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NPI-1:0]   pattern,
  input  logic [NF-1:0]    universe,
  output logic             busy,
  output logic             done,
  output logic [NF-1:0]    detected,
  output logic [NW-1:0]    wire_vals,
  output logic [NW*NF-1:0] wire_lists
);
  logic              load, adv;
  logic [STEP_W-1:0] step_q;
  logic [NF-1:0]     univ_q;
  logic [NF-1:0]     lst_all [NW];
  logic              val_all [NW];
  gate_t             g;
  logic              ev_y;
  logic [NF-1:0]     ev_list;

  dfsim_step_ctrl #(.NUM_GATES(NUM_GATES), .STEP_W(STEP_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .step(step_q), .load(load), .adv(adv)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    univ_q <= '0;
    else if (load) univ_q <= universe;
  end

  assign g = gate_at(step_q);

  dfsim_gate_eval #(.NF(NF), .WW(WIRE_W)) eval_i (
    .kind(g.kind), .la(lst_all[g.in0]), .lb(lst_all[g.in1]),
    .va(val_all[g.in0]), .vb(val_all[g.in1]), .out_idx(g.out),
    .univ(univ_q), .y(ev_y), .lst(ev_list)
  );

  for (genvar w = 0; w < NW; w++) begin : g_wire
    logic [NF-1:0] lst_d, lst_q;
    logic          val_d, val_q, en;
    if (w < NPI) begin : g_pi
      always_comb begin
        en    = load;
        val_d = pattern[w];
        lst_d = ({{(NF-1){1'b0}}, 1'b1} << {WIRE_W'(w), ~pattern[w]}) & universe;
      end
    end else begin : g_gate
      always_comb begin
        en    = load || (adv && (g.out == WIRE_W'(w)));
        val_d = load ? 1'b0 : ev_y;
        lst_d = load ? '0   : ev_list;
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lst_q <= '0;
        val_q <= 1'b0;
      end else if (en) begin
        lst_q <= lst_d;
        val_q <= val_d;
      end
    end
    assign lst_all[w]              = lst_q;
    assign val_all[w]              = val_q;
    assign wire_lists[w*NF +: NF]  = lst_q;
    assign wire_vals[w]            = val_q;
  end

  dfsim_po_union #(.NW(NW), .NF(NF), .PO_SEL(PO_MASK)) po_i (
    .lists(wire_lists), .detected(detected)
  );
endmodule

// File: rtl/dfsim_sweep_chk.sv
module dfsim_sweep_chk
  import dfsim_pkg::*;
(
  input logic                         clk,
  input logic                         rst_n,
  input logic                         start,
  input logic                         busy,
  input logic                         done,
  input logic [STEP_W-1:0]            step,
  input logic [NUM_FAULTS-1:0]        univ,
  input logic [NUM_FAULTS-1:0]        detected,
  input logic [NUM_WIRES*NUM_FAULTS-1:0] wire_lists
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(NUM_GATES - 1);

  a_r3_last_gate_done: assert property (@(posedge clk) disable iff (!rst_n)
    busy && step == LAST |=> done && !busy);

  a_r3_done_follows_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  a_r9_busy_ignores_start: assert property (@(posedge clk) disable iff (!rst_n)
    busy && step != LAST |=> busy && step == $past(step) + 1'b1);

  a_r8_inside_universe: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (detected & ~univ) == '0);

  a_r11_hold_results: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> $stable(detected));

  a_r2_pi_single_fault: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> $countones(wire_lists[NUM_FAULTS-1:0]) <= 1);
endmodule

bind dfsim_sweep dfsim_sweep_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .step(step_q), .univ(univ_q), .detected(detected), .wire_lists(wire_lists)
);

// File: tb/dfsim_sweep_tb.sv
module dfsim_sweep_tb_top;
  localparam int NW = 11;
  localparam int NF = 22;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [2:0]       pattern = '0;
  logic [NF-1:0]    universe = '0;
  logic             busy, done;
  logic [NF-1:0]    detected;
  logic [NW-1:0]    wire_vals;
  logic [NW*NF-1:0] wire_lists;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  dfsim_sweep dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .pattern(pattern),
    .universe(universe), .busy(busy), .done(done), .detected(detected),
    .wire_vals(wire_vals), .wire_lists(wire_lists)
  );

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic inj(input int w, input logic v, input int fi);
    if (fi >= 0 && fi / 2 == w) return (fi % 2) == 1;
    return v;
  endfunction

  // explicit single-fault simulation, fi < 0 means fault-free
  function automatic logic [NW-1:0] sim(input logic [2:0] p, input int fi);
    logic a, b, f, c, d, e, g, h, j, k, m;
    a = inj(0, p[0], fi);
    b = inj(1, p[1], fi);
    f = inj(2, p[2], fi);
    c = inj(3, b, fi);
    d = inj(4, b, fi);
    e = inj(5, ~d, fi);
    g = inj(6, a & c, fi);
    h = inj(7, e & f, fi);
    j = inj(8, h | g, fi);
    k = inj(9, ~(a & e), fi);
    m = inj(10, ~(k | f), fi);
    return {m, k, j, h, g, e, d, c, f, b, a};
  endfunction

  function automatic logic [NF-1:0] ref_list(input logic [2:0] p, input logic [NF-1:0] u, input int w);
    logic [NW-1:0] gv, fv;
    logic [NF-1:0] r;
    gv = sim(p, -1);
    r  = '0;
    for (int fi = 0; fi < NF; fi++) begin
      fv = sim(p, fi);
      if (u[fi] && fv[w] != gv[w]) r[fi] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic ctl_hit(input logic [NW-1:0] v, input int w);
    case (w)
      5:  return v[4] == 1'b0;
      6:  return !v[0] || !v[3];
      7:  return !v[5] || !v[2];
      8:  return v[7] || v[6];
      9:  return !v[0] || !v[5];
      default: return v[9] || v[2];
    endcase
  endfunction

  task automatic run(input logic [2:0] p, input logic [NF-1:0] u, input bit disturb);
    logic [NW-1:0] gv;
    logic [NF-1:0] det;
    @(negedge clk);
    pattern  = p;
    universe = u;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R3 busy after start", 256'(busy), 256'(1));
    chk("R11 done cleared by start", 256'(done), 256'(0));
    for (int i = 1; i < 8; i++) begin
      @(negedge clk);
      if (disturb && i == 3) begin
        pattern  = ~p;
        universe = ~u;
        start    = 1'b1;
      end else begin
        start = 1'b0;
      end
    end
    chk("R3 done not early", 256'(done), 256'(0));
    @(negedge clk);
    pattern  = ~p;
    universe = ~u;
    chk("R3 done on eighth gate", 256'(done), 256'(1));
    chk("R3 busy dropped", 256'(busy), 256'(0));
    gv  = sim(p, -1);
    det = '0;
    for (int w = 0; w < NW; w++) begin
      logic [NF-1:0] e;
      e = ref_list(p, u, w);
      if (w == 8 || w == 10) det = det | e;
      if (w < 5)              chk(disturb ? "R9 R2 list" : "R2 list", 256'(wire_lists[w*NF +: NF]), 256'(e));
      else if (ctl_hit(gv, w)) chk(disturb ? "R9 R5 list" : "R5 list", 256'(wire_lists[w*NF +: NF]), 256'(e));
      else                    chk(disturb ? "R9 R4 list" : "R4 list", 256'(wire_lists[w*NF +: NF]), 256'(e));
    end
    chk("R6 good values", 256'(wire_vals), 256'(gv));
    chk("R7 detected union", 256'(detected), 256'(det));
    chk("R8 universe only", 256'(detected & ~u), 256'(0));
  endtask

  initial begin
    logic [NF-1:0] hold;
    void'($urandom(32'd1234));
    #1;
    chk("R1 reset busy", 256'(busy), 256'(0));
    chk("R1 reset done", 256'(done), 256'(0));
    chk("R1 reset lists", 256'(wire_lists), 256'(0));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", 256'({busy, done, detected, wire_vals}), 256'(0));

    // R10 directed example
    run(3'b101, '1, 1'b0);
    chk("R10 J list", 256'(wire_lists[8*NF +: NF]),
        256'((1 << 4) | (1 << 9) | (1 << 10) | (1 << 14) | (1 << 16)));

    // R11 hold while done
    hold = detected;
    repeat (4) @(negedge clk);
    chk("R11 detected held", 256'(detected), 256'(hold));
    chk("R11 done held", 256'(done), 256'(1));

    // R9 start during sweep
    run(3'b010, '1, 1'b1);
    run(3'b000, 22'h3f_f0f0, 1'b1);

    // R8 restricted universe: only B/1, F/0, J/0
    run(3'b101, (22'(1) << 3) | (22'(1) << 4) | (22'(1) << 16), 1'b0);

    for (int i = 0; i < 8; i++) run(3'(i), '1, 1'b0);
    for (int i = 0; i < 30; i++) begin
      logic [NF-1:0] u;
      u = ($urandom % 2 == 0) ? '1 : NF'($urandom);
      run(3'($urandom), u, ($urandom % 4) == 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule